// File: doc/BRIEF.md
# Paired Two-Dimensional Memory Copy Engine

This block copies data from one region of memory to another. It has a source channel that reads elements and a destination channel that writes them, joined by a small word buffer, and both share a single synchronous memory port. Each channel has its own start address, inner count and stride, outer count and stride, control word and status word, all reached through a simple register write/read interface.

Elements are 8, 16 or 32 bits wide. Strides are signed byte offsets, so a copy can walk upward or downward through memory; a descending walk lets software move overlapping regions safely. In two-dimensional mode the outer stride is applied at the end of each row, which gives rectangular and strided block copies. The destination reports completion with a sticky done flag and an optional interrupt. Either channel reports a bad setup through a sticky error flag. Both flags clear when a one is written to them.

Top module: `mdma_pair`

## Requirements
- R1: After reset every register reads zero, `mem_req` and `irq` are low, and the buffer is empty.
- R2: `reg_addr[3]` selects the channel (0 source, 1 destination). `reg_addr[2:0]` selects the register: 0 start address (32 bits), 1 inner count, 2 inner stride, 3 outer count, 4 outer stride, 5 control, 6 status. Counts and strides are 16-bit fields that read back zero-extended.
- R3: The control word holds bit 0 enable, bit 1 write-to-memory, bit 2 interrupt enable, bits 4:3 element size (0 byte, 1 halfword, 2 word), bit 5 two-dimensional mode and bit 6 buffer restart. `mem_size` uses the same size code. Data is right-aligned on `mem_wdata` and `mem_rdata`, and read data is valid in the cycle after the read request.
- R4: Writing the control word with enable set starts the channel at the start address. In one-dimensional mode it moves inner-count elements and adds the sign-extended inner stride after each one. The destination writes the elements in the order the source read them.
- R5: A negative stride makes the addresses descend. An overlapping copy run from the top down gives the result of a move.
- R6: In two-dimensional mode the outer stride replaces the inner stride after the last element of each row. The transfer is inner count × outer count elements.
- R7: A count of zero means 2^CNT_W elements (65536 at the default width).
- R8: Status bit 0 (done) of the destination sets when the final element is written, and of the source when the final read is issued. The control enable bit still reads as set afterward. `irq` is high while a channel has done set and its interrupt enable set.
- R9: Status bits are write-one-to-clear: bit 0 done, bit 1 error. A written 0 leaves the bit unchanged.
- R10: When enable is written, the channel sets status bit 1 and makes no memory access if any of these holds: the start address, inner stride or (in two-dimensional mode) outer stride is not a multiple of the element size; the size code is 3; or the write-to-memory bit is wrong for the channel (source 0, destination 1).
- R11: Writing the control word with enable clear stops the channel at once, and it makes no further accesses.
- R12: The source stops issuing reads while buffered plus in-flight elements equal DEPTH. The destination writes only while the buffer holds data, and the destination has priority on the port.
- R13: Writing a control word with the restart bit set discards all buffered and in-flight data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel select and register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 2 | Element size code of the access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data, one cycle after the request |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the memory returns read data exactly one cycle after each read request and that software writes the address and stride registers before the enable. They also assume that software does not change a running channel's setup except through its control or status word. The stimulus writes every setup register before the control word and starts each transfer only after both channels are disabled and their status is cleared. The bench memory model answers every read in the next cycle. Stop and restart cases run with the sequence model paused, and only the ports are observed there.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  localparam logic [2:0] RI_START = 3'd0;
  localparam logic [2:0] RI_XCNT  = 3'd1;
  localparam logic [2:0] RI_XMOD  = 3'd2;
  localparam logic [2:0] RI_YCNT  = 3'd3;
  localparam logic [2:0] RI_YMOD  = 3'd4;
  localparam logic [2:0] RI_CTRL  = 3'd5;
  localparam logic [2:0] RI_STAT  = 3'd6;

  localparam int CB_EN    = 0;
  localparam int CB_TOMEM = 1;
  localparam int CB_IRQ   = 2;
  localparam int CB_SZ    = 3;
  localparam int CB_2D    = 5;
  localparam int CB_RST   = 6;
  localparam int CTRL_W   = 7;

  // true when v is not a multiple of the element size
  function automatic logic misaligned(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd1:    return v[0];
      2'd2:    return |v[1:0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
endpackage

// File: rtl/mdma_buf.sv
module mdma_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign dout = store[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wp] <= din;
        wp        <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/mdma_chan.sv
module mdma_chan
  import mdma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit IS_DST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        step,
  output logic        run,
  output logic [1:0]  size,
  output logic [31:0] addr,
  output logic        flush_req,
  output logic        err_evt,
  output logic        done_evt,
  output logic        irq
);
  logic [31:0]       start_q;
  logic [CNT_W-1:0]  xcnt_q, ycnt_q;
  logic [15:0]       xmod_q, ymod_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        stat_q;
  logic [CNT_W:0]    xleft, yleft;
  logic              last_elem, ctrl_wr, bad_setup;
  logic [1:0]        new_sz;

  function automatic logic [CNT_W:0] eff(input logic [CNT_W-1:0] c);
    return (c == '0) ? ((CNT_W+1)'(1) << CNT_W) : {1'b0, c};
  endfunction

  assign size      = ctrl_q[CB_SZ+1:CB_SZ];
  assign new_sz    = wr_data[CB_SZ+1:CB_SZ];
  assign ctrl_wr   = wr_en && (wr_sel == RI_CTRL);
  assign bad_setup = (new_sz == 2'd3) || misaligned(start_q, new_sz)
                  || misaligned(sext16(xmod_q), new_sz)
                  || (wr_data[CB_2D] && misaligned(sext16(ymod_q), new_sz))
                  || (wr_data[CB_TOMEM] != IS_DST);
  assign last_elem = (xleft == 1) && (yleft == 1);
  assign flush_req = ctrl_wr && wr_data[CB_RST];
  assign err_evt   = ctrl_wr && wr_data[CB_EN] && bad_setup;
  assign done_evt  = step && run && last_elem;
  assign irq       = stat_q[0] && ctrl_q[CB_IRQ];

  always_comb begin
    case (rd_sel)
      RI_START: rd_data = start_q;
      RI_XCNT:  rd_data = 32'(xcnt_q);
      RI_XMOD:  rd_data = 32'(xmod_q);
      RI_YCNT:  rd_data = 32'(ycnt_q);
      RI_YMOD:  rd_data = 32'(ymod_q);
      RI_CTRL:  rd_data = 32'(ctrl_q);
      RI_STAT:  rd_data = 32'(stat_q);
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0; xcnt_q <= '0; ycnt_q <= '0; xmod_q <= '0; ymod_q <= '0;
      ctrl_q  <= '0; stat_q <= '0; run <= 1'b0; addr <= '0;
      xleft   <= '0; yleft  <= '0;
    end else begin
      if (step && run) begin
        if (last_elem) begin
          run       <= 1'b0;
          stat_q[0] <= 1'b1;
        end else if (xleft == 1) begin
          addr  <= addr + sext16(ymod_q);
          xleft <= eff(xcnt_q);
          yleft <= yleft - 1'b1;
        end else begin
          addr  <= addr + sext16(xmod_q);
          xleft <= xleft - 1'b1;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          RI_START: start_q <= wr_data;
          RI_XCNT:  xcnt_q  <= wr_data[CNT_W-1:0];
          RI_XMOD:  xmod_q  <= wr_data[15:0];
          RI_YCNT:  ycnt_q  <= wr_data[CNT_W-1:0];
          RI_YMOD:  ymod_q  <= wr_data[15:0];
          RI_CTRL: begin
            ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_data[CB_EN]) begin
              run   <= !bad_setup;
              addr  <= start_q;
              xleft <= eff(xcnt_q);
              yleft <= wr_data[CB_2D] ? eff(ycnt_q) : (CNT_W+1)'(1);
              if (bad_setup) stat_q[1] <= 1'b1;
            end else begin
              run <= 1'b0;
            end
          end
          RI_STAT: stat_q <= stat_q & ~wr_data[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdma_pair.sv
module mdma_pair
  import mdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  logic [31:0] ch_rd   [2];
  logic [31:0] ch_addr [2];
  logic [1:0]  ch_size [2];
  logic [1:0]  ch_run, ch_step, ch_flush, ch_err, ch_done, ch_irq;

  logic          src_go, dst_go, rd_pend, flush_any;
  logic          fifo_push, fifo_pop;
  logic [CW-1:0] fifo_cnt;
  logic [31:0]   fifo_head;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    mdma_chan #(.CNT_W(CNT_W), .IS_DST(c == 1)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we && (reg_addr[3] == c[0])), .wr_sel(reg_addr[2:0]), .wr_data(reg_wdata),
      .rd_sel(reg_addr[2:0]), .rd_data(ch_rd[c]),
      .step(ch_step[c]), .run(ch_run[c]), .size(ch_size[c]), .addr(ch_addr[c]),
      .flush_req(ch_flush[c]), .err_evt(ch_err[c]), .done_evt(ch_done[c]), .irq(ch_irq[c])
    );
  end

  assign reg_rdata = reg_addr[3] ? ch_rd[1] : ch_rd[0];

  // destination first; source only when room remains counting the read in flight
  assign dst_go    = ch_run[1] && (fifo_cnt != '0);
  assign src_go    = ch_run[0] && !dst_go && ((32'(fifo_cnt) + 32'(rd_pend)) < 32'(DEPTH));
  assign ch_step   = {dst_go, src_go};
  assign flush_any = |ch_flush;
  assign fifo_push = rd_pend;
  assign fifo_pop  = dst_go;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= src_go && !flush_any;
  end

  mdma_buf #(.DEPTH(DEPTH), .W(32)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush_any),
    .push(fifo_push), .din(mem_rdata), .pop(fifo_pop),
    .dout(fifo_head), .count(fifo_cnt)
  );

  assign mem_req   = src_go || dst_go;
  assign mem_we    = dst_go;
  assign mem_addr  = dst_go ? ch_addr[1] : ch_addr[0];
  assign mem_size  = dst_go ? ch_size[1] : ch_size[0];
  assign mem_wdata = fifo_head;
  assign irq       = |ch_irq;
endmodule

// File: rtl/mdma_pair_chk.sv
module mdma_pair_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    ch_run,
  input logic [1:0]    ch_err,
  input logic [1:0]    ch_done,
  input logic          flush_any,
  input logic          fifo_pop,
  input logic [CW-1:0] fifo_cnt
);
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_cnt) <= DEPTH);
  p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_cnt != '0);
  p_write_needs_dst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ch_run[1]);
  p_src_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_err[0] |=> !(mem_req && !mem_we));
  p_dst_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_err[1] |=> !(mem_req && mem_we));
  p_dst_done_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_done[1] |-> (mem_req && mem_we));
  p_src_done_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_done[0] |-> (mem_req && !mem_we));
  p_flush_empty_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |=> fifo_cnt == '0);
endmodule

bind mdma_pair mdma_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .ch_run(ch_run), .ch_err(ch_err), .ch_done(ch_done),
  .flush_any(flush_any), .fifo_pop(fifo_pop), .fifo_cnt(fifo_cnt)
);

// File: tb/test_mdma_pair.sv
module test_mdma_pair;
  localparam int CNT_W = 8;
  localparam int DEPTH = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, irq;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  mdma_pair #(.CNT_W(CNT_W), .DEPTH(DEPTH)) i_mdma_pair (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, rd_seen = 0, wr_seen = 0;
  bit model_on = 1'b0;
  logic [7:0] mem [1024];
  int exp_ra[$], exp_wa[$], exp_wd[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: synchronous, right-aligned, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < (1 << mem_size); b++) mem[(mem_addr + b) % 1024] <= mem_wdata[8*b +: 8];
      end else begin
        logic [31:0] v;
        v = '0;
        for (int b = 0; b < (1 << mem_size); b++) v[8*b +: 8] = mem[(mem_addr + b) % 1024];
        mem_rdata <= v;
      end
    end
  end

  // reference sequence compared on every clock
  always @(negedge clk) begin
    cycles++;
    if (rst_n && mem_req) begin
      if (mem_we) wr_seen++; else rd_seen++;
      if (model_on) begin
        if (mem_we) begin
          if (exp_wa.size() == 0) check(0, "R4 unexpected write", mem_addr, 0);
          else begin
            int ea, ed;
            ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
            check(mem_addr == ea, "R4/R5/R6 write address", mem_addr, ea);
            check(mem_wdata == ed, "R4 write data", mem_wdata, ed);
          end
        end else begin
          if (exp_ra.size() == 0) check(0, "R4 unexpected read", mem_addr, 0);
          else begin
            int ea;
            ea = exp_ra.pop_front();
            check(mem_addr == ea, "R4/R5/R6 read address", mem_addr, ea);
          end
        end
      end
    end
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural plan of one copy, same strides for both sides
  task automatic plan(input int sa, input int da, input int xc, input int xm,
                      input int yc, input int ym, input int sz, input bit two);
    int nx, ny, s, d, eb;
    eb = 1 << sz;
    nx = (xc == 0) ? (1 << CNT_W) : xc;
    ny = two ? ((yc == 0) ? (1 << CNT_W) : yc) : 1;
    s = sa; d = da;
    for (int y = 0; y < ny; y++)
      for (int x = 0; x < nx; x++) begin
        int v;
        v = 0;
        for (int b = 0; b < eb; b++) v |= int'(mem[(s + b) % 1024]) << (8 * b);
        exp_ra.push_back(s); exp_wa.push_back(d); exp_wd.push_back(v);
        if (x == nx - 1) begin s += ym; d += ym; end
        else begin s += xm; d += xm; end
      end
  endtask

  task automatic setup(input int ch, input int sa, input int xc, input int xm,
                       input int yc, input int ym);
    wr(4'(ch * 8 + 0), sa);
    wr(4'(ch * 8 + 1), xc);
    wr(4'(ch * 8 + 2), xm & 16'hFFFF);
    wr(4'(ch * 8 + 3), yc);
    wr(4'(ch * 8 + 4), ym & 16'hFFFF);
  endtask

  task automatic clean();
    wr(4'd5, 0); wr(4'd13, 0); wr(4'd6, 3); wr(4'd14, 3);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] st;
    int n;
    n = 0;
    do begin @(negedge clk); rd(4'd14, st); n++; end while (!st[0] && n < 5000);
    check(st[0] == 1'b1, {tag, " R8 destination done"}, st, 1);
    idle(2);
    check(exp_wa.size() == 0 && exp_ra.size() == 0, {tag, " R4 all elements moved"},
          exp_wa.size(), 0);
  endtask

  // control words: en=1 tomem=2 irq=4 size<<3 2D=32 restart=64
  function automatic int src_ctrl(input int sz, input bit two);
    return 1 | (sz << 3) | (two ? 32 : 0);
  endfunction
  function automatic int dst_ctrl(input int sz, input bit two);
    return 1 | 2 | 4 | (sz << 3) | (two ? 32 : 0);
  endfunction

  initial begin
    logic [31:0] v;
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    mem_rdata = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd5, v);  check(v == 0, "R1 source control after reset", v, 0);
    rd(4'd14, v); check(v == 0, "R1 destination status after reset", v, 0);
    check(mem_req == 0 && irq == 0, "R1 port idle after reset", {mem_req, irq}, 0);

    // R2 register map readback
    wr(4'd0, 32'h1234_5678); rd(4'd0, v); check(v == 32'h1234_5678, "R2 start readback", v, 32'h1234_5678);
    wr(4'd10, 32'hFFFF_FFFE); rd(4'd10, v); check(v == 32'h0000_FFFE, "R2 stride zero-extended", v, 32'hFFFE);
    wr(4'd11, 32'h0000_0005); rd(4'd11, v); check(v == 5, "R2 outer count readback", v, 5);
    rd(4'd3, v); check(v == 0, "R2 channels independent", v, 0);

    // R4 R3 R12 R8: 32-bit upward copy, source first to show the buffer limit
    model_on = 1'b1;
    plan(32'h040, 32'h080, 8, 4, 0, 0, 2, 0);
    setup(0, 32'h040, 8, 4, 0, 0);
    setup(1, 32'h080, 8, 4, 0, 0);
    r0 = rd_seen;
    wr(4'd5, src_ctrl(2, 0));
    idle(20);
    check(rd_seen - r0 == DEPTH, "R12 source stalls when buffer full", rd_seen - r0, DEPTH);
    check(wr_seen == 0, "R12 no write while destination off", wr_seen, 0);
    wr(4'd13, dst_ctrl(2, 0));
    wait_done("32-bit");
    rd(4'd5, v); check(v[0] == 1, "R8 source enable still set after done", v[0], 1);
    rd(4'd6, v); check(v[0] == 1, "R8 source done set", v[0], 1);
    check(irq == 1, "R8 irq with done and enable", irq, 1);
    wr(4'd14, 32'h2); #1;
    check(irq == 1, "R9 writing 0 to done leaves it", irq, 1);
    wr(4'd14, 32'h1); #1;
    check(irq == 0, "R9 write-one clears done", irq, 0);
    clean();

    // R5: 16-bit overlapping copy from the top down
    plan(32'h10A, 32'h10C, 6, -2, 0, 0, 1, 0);
    setup(0, 32'h10A, 6, -2, 0, 0);
    setup(1, 32'h10C, 6, -2, 0, 0);
    wr(4'd5, src_ctrl(1, 0)); wr(4'd13, dst_ctrl(1, 0));
    wait_done("descending");
    clean();

    // R6: 8-bit 2D, 3 per row, 2 rows, row step 5
    plan(32'h200, 32'h300, 3, 1, 2, 5, 0, 1);
    setup(0, 32'h200, 3, 1, 2, 5);
    setup(1, 32'h300, 3, 1, 2, 5);
    wr(4'd5, src_ctrl(0, 1)); wr(4'd13, dst_ctrl(0, 1));
    wait_done("2D");
    check(mem[32'h309] == mem[32'h209], "R6 last element of second row", mem[32'h309], mem[32'h209]);
    clean();

    // R7: count zero means 2^CNT_W elements
    plan(32'h000, 32'h200, 0, 1, 0, 0, 0, 0);
    r0 = wr_seen;
    setup(0, 32'h000, 0, 1, 0, 0);
    setup(1, 32'h200, 0, 1, 0, 0);
    wr(4'd5, src_ctrl(0, 0)); wr(4'd13, dst_ctrl(0, 0));
    wait_done("count-zero");
    check(wr_seen - r0 == (1 << CNT_W), "R7 zero count element total", wr_seen - r0, 1 << CNT_W);
    clean();
    model_on = 1'b0;

    // R10: misaligned 16-bit start, then wrong direction on destination
    setup(0, 32'h101, 4, 2, 0, 0);
    r0 = rd_seen;
    wr(4'd5, src_ctrl(1, 0));
    idle(10);
    rd(4'd6, v); check(v[1] == 1, "R10 misaligned start sets error", v, 2);
    check(rd_seen == r0, "R10 no access after error", rd_seen - r0, 0);
    wr(4'd6, 32'h1); rd(4'd6, v); check(v[1] == 1, "R9 writing 0 to error leaves it", v, 2);
    wr(4'd6, 32'h2); rd(4'd6, v); check(v == 0, "R9 write-one clears error", v, 0);
    setup(1, 32'h100, 4, 1, 0, 0);
    wr(4'd13, 1);
    rd(4'd14, v); check(v[1] == 1, "R10 destination without write bit errors", v, 2);
    clean();

    // R11: stop the source in the middle of a run
    setup(0, 32'h000, 40, 1, 0, 0);
    setup(1, 32'h380, 40, 1, 0, 0);
    wr(4'd5, src_ctrl(0, 0)); wr(4'd13, dst_ctrl(0, 0));
    idle(6);
    wr(4'd5, 0);
    idle(2);
    r0 = rd_seen;
    idle(12);
    check(rd_seen == r0, "R11 no reads after stop", rd_seen - r0, 0);
    wr(4'd13, 0);
    r0 = wr_seen;
    idle(5);
    check(wr_seen == r0, "R11 no writes after destination stop", wr_seen - r0, 0);
    clean();

    // R13: fill the buffer, stop, restart-flush, then destination finds nothing
    setup(0, 32'h000, 20, 1, 0, 0);
    wr(4'd5, src_ctrl(0, 0));
    idle(10);
    wr(4'd5, 0);
    wr(4'd5, 32'h40);
    setup(1, 32'h380, 3, 1, 0, 0);
    r0 = wr_seen;
    wr(4'd13, dst_ctrl(0, 0));
    idle(10);
    check(wr_seen == r0, "R13 restart discards buffered data", wr_seen - r0, 0);
    clean();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule